// File: doc/BRIEF.md
# Two-Phase Self-Test Sequencer

This controller runs a self-test of a three-register pipeline. Register A feeds logic block L1. L1 feeds register B, and B feeds logic block L2, which feeds register C. Each register has four modes: normal parallel load, pseudo-random pattern generation, signature compaction, and serial scan. The sequencer drives the mode of each register and issues a seed strobe before each test phase. It counts patterns and shift cycles, and checks the scanned-out signatures against expected values given as parameters.

The test has two phases. First, A generates patterns while B compacts the responses of L1. The whole chain is then shifted out and B's signature is captured and compared. Second, B becomes the generator and C compacts the responses of L2. C's signature is then shifted out and compared. A fail flag is kept for each logic block, and a one-cycle done pulse marks the end of the test.

The scan chain runs A to B to C. The chain output is the MSB of C, and each shift moves every bit one place toward that output.

Top module: `bistSeqTop`

## Requirements
- R1: While reset is high and just after it, all three mode outputs are normal (00), seedLoad is 000, and done, failL1 and failL2 are 0.
- R2: seedLoad is nonzero in exactly two cycles of a test, and all modes are normal in those cycles. The first is the cycle after start is accepted, with value 001 (register A). The second is the cycle after the first comparison, with value 010 (register B). In both cycles seedData equals SEED.
- R3: Mode encoding is normal=00, generate=01, compact=10, scan=11. In phase one, for PATTERNS cycles, modeA=01, modeB=10 and modeC=00.
- R4: After phase one, all modes are 11 for 2*WIDTH cycles while scanIn is captured. If the last WIDTH captured bits (first bit as MSB) differ from EXP_SIG1, failL1 is set.
- R5: In phase two, for PATTERNS cycles, modeA=00, modeB=01 and modeC=10.
- R6: After phase two, all modes are 11 for WIDTH cycles. If the captured bits differ from EXP_SIG2, failL2 is set.
- R7: done is high for exactly one cycle, 2*PATTERNS+3*WIDTH+4 cycles after the edge that accepts start. The controller is idle, with all modes normal, the cycle after.
- R8: A start pulse while a test runs has no effect: the timing of done and the modes are unchanged.
- R9: Accepting start clears both fail flags. After done, the flags hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a test when idle |
| scanIn | input | 1 | Serial output of the register scan chain |
| modeA | output | 2 | Mode of register A |
| modeB | output | 2 | Mode of register B |
| modeC | output | 2 | Mode of register C |
| seedLoad | output | 3 | One-hot seed strobe, bit 0 = A, bit 1 = B, bit 2 = C |
| seedData | output | WIDTH | Seed value for the generator |
| done | output | 1 | End-of-test pulse |
| failL1 | output | 1 | L1 signature mismatch |
| failL2 | output | 1 | L2 signature mismatch |

## Verification
A wrong sequencer state shows at the ports within one cycle. A register gets the wrong role, or a seed strobe lands outside its slot. Either one also changes the signatures of the modelled pipeline, so a fault-free run then reports a failure at done. A counter off by one moves done from its fixed cycle and shifts the capture window by a bit, which corrupts the comparison. Faults injected into L1 or L2 must raise only the flag of that block.

// File: rtl/bistSeqPkg.sv
package bistSeqPkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_PRBS   = 2'b01,
    MODE_SIG    = 2'b10,
    MODE_SCAN   = 2'b11
  } regMode_t;

  typedef struct packed {
    logic capEn;
    logic cmpEn;
    logic cmpSel;
    logic clrFlags;
  } dpStrobe_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SEED1, ST_GEN1, ST_SCAN1, ST_CMP1,
    ST_SEED2, ST_GEN2, ST_SCAN2, ST_CMP2, ST_FIN
  } seqState_t;
endpackage

// File: rtl/bistSeqCtrl.sv
module bistSeqCtrl
  import bistSeqPkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int PATTERNS = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic [1:0] modeVec [3],
  output logic [2:0] seedLoad,
  output logic       done,
  output dpStrobe_t  strobe
);
  localparam int LONGEST = (PATTERNS > 2 * WIDTH) ? PATTERNS : 2 * WIDTH;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  seqState_t state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (start) state <= ST_SEED1;
        ST_SEED1: begin state <= ST_GEN1; cnt <= CNT_W'(PATTERNS - 1); end
        ST_GEN1:
          if (cnt == '0) begin
            state <= ST_SCAN1;
            cnt   <= CNT_W'(2 * WIDTH - 1);
          end else cnt <= cnt - 1'b1;
        ST_SCAN1: if (cnt == '0) state <= ST_CMP1; else cnt <= cnt - 1'b1;
        ST_CMP1:  state <= ST_SEED2;
        ST_SEED2: begin state <= ST_GEN2; cnt <= CNT_W'(PATTERNS - 1); end
        ST_GEN2:
          if (cnt == '0) begin
            state <= ST_SCAN2;
            cnt   <= CNT_W'(WIDTH - 1);
          end else cnt <= cnt - 1'b1;
        ST_SCAN2: if (cnt == '0) state <= ST_CMP2; else cnt <= cnt - 1'b1;
        ST_CMP2:  state <= ST_FIN;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  logic       inGen, inScan, seeding;
  logic [1:0] genIdx;

  always_comb begin
    inGen   = (state == ST_GEN1) || (state == ST_GEN2);
    inScan  = (state == ST_SCAN1) || (state == ST_SCAN2);
    seeding = (state == ST_SEED1) || (state == ST_SEED2);
    genIdx  = ((state == ST_SEED2) || (state == ST_GEN2)) ? 2'd1 : 2'd0;
  end

  for (genvar g = 0; g < 3; g++) begin : gRole
    always_comb begin
      if (inScan)                                  modeVec[g] = MODE_SCAN;
      else if (inGen && genIdx == 2'(g))           modeVec[g] = MODE_PRBS;
      else if (inGen && genIdx + 2'd1 == 2'(g))    modeVec[g] = MODE_SIG;
      else                                         modeVec[g] = MODE_NORMAL;
    end
    assign seedLoad[g] = seeding && (genIdx == 2'(g));
  end

  always_comb begin
    strobe.capEn    = inScan;
    strobe.cmpEn    = (state == ST_CMP1) || (state == ST_CMP2);
    strobe.cmpSel   = (state == ST_CMP2);
    strobe.clrFlags = (state == ST_IDLE) && start;
    done            = (state == ST_FIN);
  end
endmodule

// File: rtl/bistSigCheck.sv
module bistSigCheck
  import bistSeqPkg::*;
#(
  parameter int              WIDTH    = 8,
  parameter logic [WIDTH-1:0] EXP_SIG1 = '0,
  parameter logic [WIDTH-1:0] EXP_SIG2 = '0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      scanIn,
  input  dpStrobe_t strobe,
  output logic      failL1,
  output logic      failL2
);
  logic [WIDTH-1:0] capReg;
  logic             mismatch;

  always_comb mismatch = capReg != (strobe.cmpSel ? EXP_SIG2 : EXP_SIG1);

  always_ff @(posedge clk) begin
    if (rst) begin
      capReg <= '0;
      failL1 <= 1'b0;
      failL2 <= 1'b0;
    end else begin
      if (strobe.capEn) capReg <= {capReg[WIDTH-2:0], scanIn};
      if (strobe.clrFlags) begin
        failL1 <= 1'b0;
        failL2 <= 1'b0;
      end else if (strobe.cmpEn) begin
        if (strobe.cmpSel) failL2 <= mismatch;
        else               failL1 <= mismatch;
      end
    end
  end
endmodule

// File: rtl/bistSeqTop.sv
module bistSeqTop
  import bistSeqPkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter int               PATTERNS = 20,
  parameter logic [WIDTH-1:0] SEED     = 8'h5A,
  parameter logic [WIDTH-1:0] EXP_SIG1 = '0,
  parameter logic [WIDTH-1:0] EXP_SIG2 = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             scanIn,
  output logic [1:0]       modeA,
  output logic [1:0]       modeB,
  output logic [1:0]       modeC,
  output logic [2:0]       seedLoad,
  output logic [WIDTH-1:0] seedData,
  output logic             done,
  output logic             failL1,
  output logic             failL2
);
  logic [1:0] modeVec [3];
  dpStrobe_t  strobe;

  bistSeqCtrl #(.WIDTH(WIDTH), .PATTERNS(PATTERNS)) i_ctrl (
    .clk(clk), .rst(rst), .start(start), .modeVec(modeVec),
    .seedLoad(seedLoad), .done(done), .strobe(strobe)
  );

  bistSigCheck #(.WIDTH(WIDTH), .EXP_SIG1(EXP_SIG1), .EXP_SIG2(EXP_SIG2)) i_sig (
    .clk(clk), .rst(rst), .scanIn(scanIn), .strobe(strobe),
    .failL1(failL1), .failL2(failL2)
  );

  assign modeA    = modeVec[0];
  assign modeB    = modeVec[1];
  assign modeC    = modeVec[2];
  assign seedData = SEED;
endmodule

// File: rtl/bistSeqChk.sv
module bistSeqChk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] modeA,
  input logic [1:0] modeB,
  input logic [1:0] modeC,
  input logic [2:0] seedLoad,
  input logic       done,
  input logic       failL1,
  input logic       failL2
);
  AST_SEED_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(seedLoad)); // R2
  AST_SEED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (seedLoad != 3'b000) |-> (modeA == 2'b00 && modeB == 2'b00 && modeC == 2'b00)); // R2
  AST_PHASE1_ROLES: assert property (@(posedge clk) disable iff (rst)
    (modeA == 2'b01) |-> (modeB == 2'b10 && modeC == 2'b00)); // R3
  AST_PHASE2_ROLES: assert property (@(posedge clk) disable iff (rst)
    (modeB == 2'b01) |-> (modeC == 2'b10 && modeA == 2'b00)); // R5
  AST_SCAN_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    (modeA == 2'b11 || modeB == 2'b11 || modeC == 2'b11)
      |-> (modeA == 2'b11 && modeB == 2'b11 && modeC == 2'b11)); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (modeA == 2'b00 && modeB == 2'b00 && modeC == 2'b00 && seedLoad == 3'b000)); // R7
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
    done |=> ($stable(failL1) && $stable(failL2))); // R9
endmodule

bind bistSeqTop bistSeqChk i_chk (
  .clk(clk), .rst(rst), .modeA(modeA), .modeB(modeB), .modeC(modeC),
  .seedLoad(seedLoad), .done(done), .failL1(failL1), .failL2(failL2)
);

// File: tb/test_bistSeqTop.sv
module test_bistSeqTop;
  localparam int          CLK_PERIOD = 10;
  localparam int          W    = 8;
  localparam int          P    = 20;
  localparam logic [7:0]  SEED = 8'h5A;

  function automatic logic [7:0] prbs(input logic [7:0] r);
    return {r[6:0], r[7] ^ r[5] ^ r[4] ^ r[3]};
  endfunction
  function automatic logic [7:0] logicL1(input logic [7:0] x, input logic f);
    logic [7:0] y;
    y = (x + 8'h35) ^ {x[3:0], x[7:4]};
    return f ? (y | 8'h04) : y;
  endfunction
  function automatic logic [7:0] logicL2(input logic [7:0] x, input logic f);
    logic [7:0] y;
    y = x ^ {x[6:0], x[7]} ^ 8'hC3;
    return f ? (y & 8'hFE) : y;
  endfunction
  function automatic logic [7:0] regNext(input logic [7:0] r, input logic [1:0] m,
      input logic [7:0] par, input logic sIn, input logic ld);
    if (ld) return SEED;
    case (m)
      2'b01:   return prbs(r);
      2'b10:   return prbs(r) ^ par;
      2'b11:   return {r[6:0], sIn};
      default: return par;
    endcase
  endfunction
  // state {C,B,A}; modes {mC,mB,mA}; A normal = hold
  function automatic logic [23:0] envStep(input logic [23:0] st, input logic [5:0] md,
      input logic [2:0] ld, input logic [1:0] flt);
    logic [7:0] a, b, c;
    a = st[7:0]; b = st[15:8]; c = st[23:16];
    return {regNext(c, md[5:4], logicL2(b, flt[1]), b[7], ld[2]),
            regNext(b, md[3:2], logicL1(a, flt[0]), a[7], ld[1]),
            regNext(a, md[1:0], a, 1'b0, ld[0])};
  endfunction
  function automatic logic [15:0] calcSigs(input logic [1:0] flt);
    logic [23:0] st;
    logic [7:0]  cap, s1;
    st  = '0;
    cap = '0;
    st = envStep(st, 6'b000000, 3'b001, flt);
    for (int i = 0; i < P; i++) st = envStep(st, 6'b001001, 3'b000, flt);
    for (int i = 0; i < 2 * W; i++) begin
      cap = {cap[6:0], st[23]};
      st  = envStep(st, 6'b111111, 3'b000, flt);
    end
    s1 = cap;
    st = envStep(st, 6'b000000, 3'b000, flt);
    st = envStep(st, 6'b000000, 3'b010, flt);
    for (int i = 0; i < P; i++) st = envStep(st, 6'b100100, 3'b000, flt);
    for (int i = 0; i < W; i++) begin
      cap = {cap[6:0], st[23]};
      st  = envStep(st, 6'b111111, 3'b000, flt);
    end
    return {cap, s1};
  endfunction

  localparam logic [15:0] GOLD = calcSigs(2'b00);

  logic       clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic       scanIn, done, failL1, failL2;
  logic [1:0] modeA, modeB, modeC;
  logic [2:0] seedLoad;
  logic [7:0] seedData;
  logic [23:0] env = '0;
  logic [1:0]  fault = 2'b00;
  logic [1:0]  expQ[$];
  int checkCount = 0, failCount = 0, k = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  bistSeqTop #(.WIDTH(W), .PATTERNS(P), .SEED(SEED),
               .EXP_SIG1(GOLD[7:0]), .EXP_SIG2(GOLD[15:8])) i_bistSeqTop (
    .clk(clk), .rst(rst), .start(start), .scanIn(scanIn), .modeA(modeA),
    .modeB(modeB), .modeC(modeC), .seedLoad(seedLoad), .seedData(seedData),
    .done(done), .failL1(failL1), .failL2(failL2)
  );

  assign scanIn = env[23];
  always_ff @(posedge clk) env <= envStep(env, {modeC, modeB, modeA}, seedLoad, fault);

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic stepTo(input int target);
    while (k < target) begin
      @(negedge clk);
      k++;
    end
  endtask

  // monitor: scoreboard pop at each done
  always @(negedge clk) begin
    if (!rst && done) begin
      if (expQ.size() == 0) check(1'b0, "R7 unexpected done", 32'd1, 32'd0);
      else begin
        logic [1:0] e;
        e = expQ.pop_front();
        check({failL2, failL1} == e, "R4/R6 fail flags {L2,L1}", {30'd0, failL2, failL1}, {30'd0, e});
      end
    end
  end

  task automatic runTest(input logic [1:0] flt);
    logic [15:0] s;
    logic [1:0]  e;
    s = calcSigs(flt);
    e = {s[15:8] != GOLD[15:8], s[7:0] != GOLD[7:0]};
    fault = flt;
    expQ.push_back(e);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    check(seedLoad == 3'b001 && seedData == SEED, "R2 first seed", {21'd0, seedLoad, seedData}, {21'd0, 3'b001, SEED});
    check(!failL1 && !failL2, "R9 flags cleared", {30'd0, failL2, failL1}, 32'd0);
    stepTo(1);
    check({modeC, modeB, modeA} == 6'b001001, "R3 phase one roles", {26'd0, modeC, modeB, modeA}, 32'b001001);
    stepTo(3);
    start = 1'b1;   // R8 stray start
    stepTo(4);
    start = 1'b0;
    stepTo(P + 1);
    check({modeC, modeB, modeA} == 6'b111111, "R4 scan after phase one", {26'd0, modeC, modeB, modeA}, 32'b111111);
    stepTo(P + 2 * W);
    check({modeC, modeB, modeA} == 6'b111111, "R4 last scan cycle", {26'd0, modeC, modeB, modeA}, 32'b111111);
    stepTo(P + 2 * W + 2);
    check(seedLoad == 3'b010, "R2 second seed", {29'd0, seedLoad}, 32'b010);
    stepTo(P + 2 * W + 3);
    check({modeC, modeB, modeA} == 6'b100100, "R5 phase two roles", {26'd0, modeC, modeB, modeA}, 32'b100100);
    stepTo(2 * P + 2 * W + 3);
    check({modeC, modeB, modeA} == 6'b111111, "R6 scan after phase two", {26'd0, modeC, modeB, modeA}, 32'b111111);
    stepTo(2 * P + 3 * W + 3);
    check(!done, "R7 done not early", {31'd0, done}, 32'd0);
    stepTo(2 * P + 3 * W + 4);
    check(done, "R7/R8 done on time", {31'd0, done}, 32'd1);
    stepTo(2 * P + 3 * W + 6);
    check(!done && {modeC, modeB, modeA} == 6'd0, "R7 back to idle", {25'd0, done, modeC, modeB, modeA}, 32'd0);
    check({failL2, failL1} == e, "R9 flags held", {30'd0, failL2, failL1}, {30'd0, e});
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(modeA == 2'b00 && modeB == 2'b00 && modeC == 2'b00 && seedLoad == 3'b000 &&
          !done && !failL1 && !failL2, "R1 reset state",
          {23'd0, done, failL2, failL1, seedLoad, modeA == 2'b00, modeB == 2'b00, modeC == 2'b00}, {29'd0, 3'b111});
    rst = 1'b0;
    @(negedge clk);
    check(modeA == 2'b00 && seedLoad == 3'b000 && !done, "R1 idle after reset", {27'd0, modeA, seedLoad}, 32'd0);
    runTest(2'b00);
    runTest(2'b01);
    runTest(2'b10);
    runTest(2'b00);
    runTest(2'b11);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7 one done per test", expQ.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule